// File: doc/BRIEF.md
# Power-to-Pulse Frequency Converter

This block turns a stream of signed per-phase power samples into a train of output pulses whose rate is proportional to the total power. On every sample strobe it forms a total from up to three phase inputs. Each phase can be included or left out, and the total is either a signed sum or a sum of magnitudes. The total, multiplied by a rate numerator, is added to a signed energy accumulator. A pulse is emitted whenever the accumulator reaches a threshold equal to a base constant times a rate denominator, and the threshold is then subtracted.

The width of each output pulse depends on the measured spacing between pulses and on how the numerator compares with the denominator. The numerator and denominator are expected to stay fixed while pulses are running, and the denominator must be at least 1. Computing the power samples is the job of upstream logic.

Top module: `p2f_converter`

## Requirements
- R1: While `rst` is high and afterwards, until the first qualifying sample, `pulse_out` is 0. Reset clears the accumulator and the period counter, and no pulse appears without sample strobes.
- R2: `phase_en` bit 0 includes `smp_a`, bit 1 includes `smp_b` and bit 2 includes `smp_c` in the total. A disabled phase contributes 0, and with all bits clear the total is 0.
- R3: With `abs_mode` = 0 the total is the signed sum of the enabled samples. With `abs_mode` = 1 it is the sum of their magnitudes and is never negative.
- R4: Each strobe adds total × `rate_num` to the accumulator. When the result is at least THR_BASE × `rate_den`, one pulse is issued and the threshold is subtracted. At most one pulse is issued per strobe, so after N strobes of constant total T starting from reset, floor(N·T·num / (THR_BASE·den)) pulses have been issued whenever T·num ≤ THR_BASE·den. Without a strobe the accumulator holds.
- R5: A negative total issues no pulse and lowers the accumulator, which saturates at its most negative value instead of wrapping. Later positive totals must first pay back that deficit before pulses resume.
- R6: `pulse_out` rises at the second rising clock edge after the edge that samples a strobe that causes a pulse.
- R7: When `rate_num` equals `rate_den`, each pulse is EQ_WIDTH clock cycles wide (64 by default).
- R8: When `rate_den` exceeds `rate_num`, each pulse is max(1, floor(P·h / den)) cycles wide. P is the number of clock cycles since the previous pulse started (or since reset), and h = (den+1)/2 is half the denominator rounded to the nearest integer, with halves rounded up.
- R9: When `rate_num` exceeds `rate_den`, each pulse is EQ_WIDTH cycles wide.
- R10: When P exceeds LONG_CLKS, the pulse is LONG_WIDTH cycles wide regardless of the rate ratio. This rule takes priority over R7 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe: the three sample words are valid in this cycle |
| smp_a | input | SW | Signed power sample, phase A |
| smp_b | input | SW | Signed power sample, phase B |
| smp_c | input | SW | Signed power sample, phase C |
| phase_en | input | 3 | Per-phase include bits (bit 0 = A, bit 1 = B, bit 2 = C) |
| abs_mode | input | 1 | 1 = sum magnitudes, 0 = signed sum |
| rate_num | input | NW | Rate scaling numerator |
| rate_den | input | NW | Rate scaling denominator (at least 1) |
| pulse_out | output | 1 | Registered pulse train output |

## Verification
The bench builds the converter with 8-bit samples, 4-bit rate words, THR_BASE = 32, EQ_WIDTH = 64, LONG_CLKS = 600 and LONG_WIDTH = 40. With these values a few dozen strobes spaced 40 clocks apart produce pulse periods from 80 to over 1000 cycles. That range covers the fixed, fractional and long-period width rules in short runs. It sweeps all eight phase-enable patterns in both summing modes, several num/den ratios, a negative-then-positive recovery sequence, and the strobe-to-pulse latency. It predicts pulse counts and widths arithmetically from the measured pulse spacing.

// File: rtl/p2f_pkg.sv
package p2f_pkg;

  localparam int NPH = 3;

  typedef enum logic [1:0] {
    WM_FIXED = 2'd0,
    WM_FRAC  = 2'd1,
    WM_LONG  = 2'd2
  } width_mode_e;

  function automatic int sum_width(input int sw);
    return sw + $clog2(NPH) + 1;
  endfunction

endpackage

// File: rtl/p2f_phase_sum.sv
module p2f_phase_sum
  import p2f_pkg::*;
#(
  parameter int SW   = 24,
  parameter int SUMW = sum_width(SW)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [NPH-1:0][SW-1:0]    smp,
  input  logic [NPH-1:0]            en,
  input  logic                      abs_mode,
  output logic signed [SUMW-1:0]    tot,
  output logic                      tot_v
);

  logic signed [SW:0]   term [NPH];
  logic signed [SUMW-1:0] sum_c;

  for (genvar i = 0; i < NPH; i++) begin : g_term
    logic signed [SW:0] ext;
    assign ext = $signed({smp[i][SW-1], smp[i]});
    always_comb begin
      if (!en[i])
        term[i] = '0;
      else if (abs_mode && ext[SW])
        term[i] = -ext;
      else
        term[i] = ext;
    end
  end

  always_comb begin
    sum_c = '0;
    for (int k = 0; k < NPH; k++)
      sum_c = sum_c + SUMW'(term[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tot   <= '0;
      tot_v <= 1'b0;
    end else begin
      tot_v <= in_valid;
      if (in_valid)
        tot <= sum_c;
    end
  end

  AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (rst)
    in_valid && abs_mode |=> !tot[SUMW-1]); // R3
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && (en == '0) |=> tot == '0); // R2

endmodule

// File: rtl/p2f_accum.sv
module p2f_accum #(
  parameter int SUMW     = 27,
  parameter int NW       = 12,
  parameter int THR_BASE = 1 << 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [SUMW-1:0] tot,
  input  logic                   tot_v,
  input  logic [NW-1:0]          num,
  input  logic [NW-1:0]          den,
  output logic                   fire
);

  localparam int THRW  = $clog2(THR_BASE + 1);
  localparam int INCW  = SUMW + NW + 1;
  localparam int BIGW  = (INCW > THRW + NW + 1) ? INCW : THRW + NW + 1;
  localparam int ACC_W = BIGW + 1;
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};

  logic signed [ACC_W-1:0] acc;
  logic signed [NW:0]      num_s, den_s;
  logic signed [ACC_W-1:0] inc_s, thr_s, sat;
  logic signed [ACC_W:0]   sum_w;

  assign num_s = $signed({1'b0, num});
  assign den_s = $signed({1'b0, den});
  assign inc_s = ACC_W'(tot) * ACC_W'(num_s);
  assign thr_s = ACC_W'(THR_BASE) * ACC_W'(den_s);
  assign sum_w = {acc[ACC_W-1], acc} + {inc_s[ACC_W-1], inc_s};

  always_comb begin
    if (sum_w[ACC_W] != sum_w[ACC_W-1])
      sat = sum_w[ACC_W] ? ACC_MIN : ACC_MAX;
    else
      sat = sum_w[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      fire <= 1'b0;
    end else if (tot_v) begin
      if (sat >= thr_s) begin
        acc  <= sat - thr_s;
        fire <= 1'b1;
      end else begin
        acc  <= sat;
        fire <= 1'b0;
      end
    end else begin
      fire <= 1'b0;
    end
  end

  AST_NEG_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
    tot_v && tot[SUMW-1] |=> !fire); // R5
  AST_NEG_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    tot_v && tot[SUMW-1] |=> acc <= $past(acc)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tot_v |=> $stable(acc) && !fire); // R4

endmodule

// File: rtl/p2f_pulse_shaper.sv
module p2f_pulse_shaper
  import p2f_pkg::*;
#(
  parameter int NW         = 12,
  parameter int PER_W      = 24,
  parameter int EQ_WIDTH   = 64,
  parameter int LONG_CLKS  = 1_800_000,
  parameter int LONG_WIDTH = 900_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          pulse_q
);

  localparam int REM_W = PER_W + NW + 1;
  localparam logic [PER_W-1:0] LONG_P = PER_W'(LONG_CLKS);
  localparam logic [PER_W-1:0] PER_MAX = '1;

  logic [PER_W-1:0] per_cnt;
  logic [REM_W-1:0] rem;
  logic [NW-1:0]    step;
  logic [NW:0]      half;
  width_mode_e      mode;
  logic [REM_W-1:0] ld_x;
  logic [NW-1:0]    ld_step;

  assign half = ({1'b0, den} + (NW+1)'(1)) >> 1;

  always_comb begin
    if (per_cnt > LONG_P)
      mode = WM_LONG;
    else if (den > num)
      mode = WM_FRAC;
    else
      mode = WM_FIXED;
  end

  always_comb begin
    case (mode)
      WM_LONG: begin
        ld_x    = REM_W'(LONG_WIDTH);
        ld_step = NW'(1);
      end
      WM_FRAC: begin
        ld_x    = REM_W'(per_cnt) * REM_W'(half);
        ld_step = den;
      end
      default: begin
        ld_x    = REM_W'(EQ_WIDTH);
        ld_step = NW'(1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      per_cnt <= '0;
    else if (fire)
      per_cnt <= PER_W'(1);
    else if (per_cnt != PER_MAX)
      per_cnt <= per_cnt + PER_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      rem     <= '0;
      step    <= '0;
    end else if (fire) begin
      pulse_q <= 1'b1;
      rem     <= ld_x;
      step    <= ld_step;
    end else if (pulse_q) begin
      if (rem < REM_W'({step, 1'b0}))
        pulse_q <= 1'b0;
      rem <= rem - REM_W'(step);
    end
  end

  AST_FIRE_RAISES: assert property (@(posedge clk) disable iff (rst)
    fire |=> pulse_q); // R6
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !pulse_q && !fire |=> !pulse_q); // R1

endmodule

// File: rtl/p2f_converter.sv
module p2f_converter
  import p2f_pkg::*;
#(
  parameter int SW         = 24,
  parameter int NW         = 12,
  parameter int THR_BASE   = 1 << 20,
  parameter int PER_W      = 24,
  parameter int EQ_WIDTH   = 64,
  parameter int LONG_CLKS  = 1_800_000,
  parameter int LONG_WIDTH = 900_000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_a,
  input  logic signed [SW-1:0] smp_b,
  input  logic signed [SW-1:0] smp_c,
  input  logic [2:0]           phase_en,
  input  logic                 abs_mode,
  input  logic [NW-1:0]        rate_num,
  input  logic [NW-1:0]        rate_den,
  output logic                 pulse_out
);

  localparam int SUMW = sum_width(SW);

  logic [NPH-1:0][SW-1:0] smp_pk;
  logic signed [SUMW-1:0] tot;
  logic                   tot_v;
  logic                   fire;

  assign smp_pk = {smp_c, smp_b, smp_a};

  p2f_phase_sum #(.SW(SW), .SUMW(SUMW)) u_sum (
    .clk      (clk),
    .rst      (rst),
    .in_valid (smp_valid),
    .smp      (smp_pk),
    .en       (phase_en),
    .abs_mode (abs_mode),
    .tot      (tot),
    .tot_v    (tot_v)
  );

  p2f_accum #(.SUMW(SUMW), .NW(NW), .THR_BASE(THR_BASE)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .tot   (tot),
    .tot_v (tot_v),
    .num   (rate_num),
    .den   (rate_den),
    .fire  (fire)
  );

  p2f_pulse_shaper #(
    .NW(NW), .PER_W(PER_W), .EQ_WIDTH(EQ_WIDTH),
    .LONG_CLKS(LONG_CLKS), .LONG_WIDTH(LONG_WIDTH)
  ) u_shape (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .num     (rate_num),
    .den     (rate_den),
    .pulse_q (pulse_out)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> !pulse_out); // R1

endmodule

// File: tb/tb_p2f_converter.sv
module tb_p2f_converter;

  localparam int SW = 8, NW = 4, THR = 32, EQW = 64, LONGC = 600, LONGW = 40;
  localparam int GAP = 40, DRAIN = 700;

  logic clk = 1'b0, rst = 1'b1, smp_valid = 1'b0, abs_mode = 1'b0;
  logic signed [SW-1:0] smp_a = '0, smp_b = '0, smp_c = '0;
  logic [2:0] phase_en = '0;
  logic [NW-1:0] rate_num = 4'd1, rate_den = 4'd1;
  logic pulse_out;

  always #4 clk = ~clk;

  p2f_converter #(.SW(SW), .NW(NW), .THR_BASE(THR), .PER_W(12), .EQ_WIDTH(EQW),
    .LONG_CLKS(LONGC), .LONG_WIDTH(LONGW)) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
    .smp_c(smp_c), .phase_en(phase_en), .abs_mode(abs_mode), .rate_num(rate_num),
    .rate_den(rate_den), .pulse_out(pulse_out));

  int n_chk = 0, n_fail = 0;
  int w_chk = 0, w_fail = 0;
  logic mon_clr = 1'b0;
  int rises, cyc, rise_cyc, hi_len, period;
  bit have_rise, w_pend, last;

  function automatic int exp_width(input int p, input int n, input int d);
    if (p > LONGC) return LONGW;               // R10
    if (d > n) begin                           // R8
      int w;
      w = (p * ((d + 1) / 2)) / d;
      return (w < 1) ? 1 : w;
    end
    return EQW;                                // R7, R9
  endfunction

  always @(negedge clk) begin
    if (mon_clr) begin
      rises = 0; cyc = 0; rise_cyc = 0; hi_len = 0; period = 0;
      have_rise = 0; w_pend = 0; last = 0;
    end else begin
      cyc++;
      if (pulse_out && !last) begin
        rises++;
        w_pend = have_rise;
        if (have_rise) period = cyc - rise_cyc;
        rise_cyc = cyc;
        have_rise = 1;
        hi_len = 0;
      end
      if (pulse_out) hi_len++;
      if (!pulse_out && last && w_pend) begin
        int e;
        e = exp_width(period, int'(rate_num), int'(rate_den));
        w_chk++;
        if (hi_len != e) begin
          w_fail++;
          $display("FAIL R7/R8/R9/R10 width period=%0d num=%0d den=%0d actual=%0d expected=%0d",
                   period, rate_num, rate_den, hi_len, e);
        end
      end
      last = pulse_out;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mon_clr = 1'b1;
    @(negedge clk);
    #1 mon_clr = 1'b0;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (GAP - 1) @(negedge clk);
    end
  endtask

  function automatic int exp_count(input int t, input int num, input int den, input int n);
    if (t * num <= 0) return 0;
    return (n * t * num) / (THR * den);
  endfunction

  task automatic run(input logic [2:0] en, input logic am, input int num, input int den,
                     input int tot, input int n, input string tag);
    phase_en = en; abs_mode = am;
    rate_num = NW'(num); rate_den = NW'(den);
    do_reset();
    feed(n);
    repeat (DRAIN) @(negedge clk);
    chk(rises == exp_count(tot, num, den, n), tag, rises, exp_count(tot, num, den, n));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + w_chk - n_fail - w_fail, n_chk + w_chk);
    $finish;
  end

  initial begin : stim
    int sgn [8];
    int mag [8];
    sgn = '{0, 5, -3, 2, 7, 12, 4, 9};
    mag = '{0, 5, 3, 8, 7, 12, 10, 15};
    smp_a = 8'sd5; smp_b = -8'sd3; smp_c = 8'sd7;

    // R1: low in reset, and no pulses without strobes
    repeat (3) @(negedge clk);
    chk(pulse_out == 1'b0, "R1 in reset", int'(pulse_out), 0);
    phase_en = 3'b111; abs_mode = 1'b1;
    do_reset();
    repeat (200) @(negedge clk);
    chk(rises == 0 && pulse_out == 1'b0, "R1 idle after reset", rises, 0);

    // R2/R3/R4 sweep over all enable patterns, both modes, num=den=1
    for (int e = 0; e < 8; e++) begin
      run(3'(e), 1'b0, 1, 1, sgn[e], 48, "R2/R3/R4 signed sum count");
      run(3'(e), 1'b1, 1, 1, mag[e], 48, "R2/R3/R4 abs sum count");
    end

    // Rate ratios: R8 fractional width, R9 wide num, R10 long cap
    run(3'b111, 1'b1, 1, 2, 15, 48, "R4/R8 ratio 1/2 count");
    run(3'b111, 1'b1, 2, 3, 15, 48, "R4/R8 ratio 2/3 count");
    run(3'b111, 1'b1, 3, 5, 15, 48, "R4/R8 ratio 3/5 count");
    run(3'b101, 1'b1, 1, 3, 12, 48, "R4/R8 ratio 1/3 count");
    run(3'b100, 1'b0, 2, 1, 7, 48, "R4/R9 ratio 2/1 count");
    run(3'b111, 1'b0, 3, 2, 9, 48, "R4/R9 ratio 3/2 count");
    run(3'b001, 1'b0, 1, 4, 5, 100, "R4/R10 long period count");
    run(3'b111, 1'b1, 0, 1, 15, 24, "R4 zero numerator count");

    // R5: negative total issues nothing, then deficit is paid back
    phase_en = 3'b010; abs_mode = 1'b0; rate_num = 4'd1; rate_den = 4'd1;
    do_reset();
    feed(48);
    repeat (100) @(negedge clk);
    chk(rises == 0, "R5 negative total no pulses", rises, 0);
    phase_en = 3'b100;
    feed(48);
    repeat (DRAIN) @(negedge clk);
    chk(rises == (48 * 7 - 48 * 3) / THR, "R5 recovery after deficit", rises, (48 * 7 - 48 * 3) / THR);

    // R6: latency from strobe to pulse
    smp_a = 8'sd8; phase_en = 3'b001; abs_mode = 1'b0; rate_num = 4'd4; rate_den = 4'd1;
    do_reset();
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    chk(pulse_out == 1'b0, "R6 low one edge after strobe", int'(pulse_out), 0);
    @(negedge clk);
    chk(pulse_out == 1'b0, "R6 low two edges after strobe", int'(pulse_out), 0);
    @(negedge clk);
    chk(pulse_out == 1'b1, "R6 high after second edge", int'(pulse_out), 1);
    repeat (100) @(negedge clk);

    chk(w_chk > 20, "R7/R8/R9/R10 width checks made", w_chk, 21);
    $display("%0d/%0d checks passed", n_chk + w_chk - n_fail - w_fail, n_chk + w_chk);
    $finish;
  end

endmodule